// File: doc/BRIEF.md
# Single-Channel Block Transfer DMA Engine

This block moves a block of words between memory and one peripheral on its own. The peripheral supplies or takes the data itself. The engine provides the memory address and the memory read or write strobe for each word, and it paces the words with a request/acknowledge handshake. While the system bus belongs to the CPU (bus grant low), the CPU sets up the engine through a small register port. This port has a block select, a 2-bit register code, read and write strobes, and a data bus. Through it the CPU loads the first memory address, the number of words, and a control word. The control word holds the direction and a go bit.

After a go with a nonzero count, the engine raises a bus request and waits for the grant. While the grant is high, each rising peripheral request causes one memory cycle. In that cycle the engine drives the current address, pulses the strobe that matches the direction and acknowledges the peripheral. It then advances the address and lowers the remaining count. When the count reaches zero, the engine releases its bus request and raises an interrupt. The interrupt stays high until the CPU writes the control register again.

The read and write strobes are split into CPU-side inputs and memory-side outputs. The CPU-side inputs are honoured only while the grant is low. The memory-side outputs are active only while the grant is high.

Top module: `blkdma_top`

## Requirements
- R1: After reset, bus request, interrupt, memory read/write strobes and peripheral acknowledge are 0, and the address and count registers read as 0.
- R2: With block select and grant low, register code 00 accesses the address register and code 01 accesses the word count. Code 10 accesses control: on write, bit 0 is the direction (0 = memory read toward the peripheral, 1 = memory write from the peripheral) and bit 1 is go; on read, bit 0 is the direction, bit 1 is busy and bit 2 is the interrupt. Code 11 reads as 0, and a write to it changes nothing.
- R3: While the grant is high, CPU register writes are ignored, and the read-data-valid output and the read data stay 0.
- R4: A go with a nonzero count raises bus request in the next cycle. Bus request stays high while any words remain.
- R5: Suppose the engine is busy, the grant is high and the peripheral request is high. In the next cycle, the engine then holds acknowledge for one memory cycle, drives the current address, and asserts memory read (direction 0) or memory write (direction 1). Only one of the two strobes is asserted.
- R6: Each completed word increments the address register by one and decrements the word count by one.
- R7: Acknowledge lasts exactly one cycle per word. No further word starts until the peripheral request has gone low and then high again.
- R8: In the cycle after the last word's acknowledge, bus request is 0 and the interrupt is 1.
- R9: A go with a count of zero raises the interrupt in the next cycle, and it raises no bus request.
- R10: The interrupt stays high until a control register write, which clears it.
- R11: While the grant is low, the memory strobes and acknowledge are 0 and the memory address output is 0. A pending peripheral request is held off until the grant arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_sel | input | 1 | CPU selects this block |
| reg_sel | input | 2 | Register code (00 address, 01 count, 10 control) |
| cpu_rd | input | 1 | CPU register read strobe |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | Register read data, 0 when not read |
| cpu_rdata_en | output | 1 | Read data valid |
| bus_grant | input | 1 | Bus handed to this block |
| bus_req | output | 1 | Request for the bus while words remain |
| mem_addr | output | AW | Memory address, 0 while grant is low |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| periph_req | input | 1 | Peripheral asks for one word |
| periph_ack | output | 1 | One-cycle acknowledge to the peripheral |
| irq | output | 1 | Block-complete interrupt |

## Verification
Some rules are checked by the assertions on every clock:
- the acknowledge is a single-cycle pulse, always paired with exactly one strobe under the grant;
- the bus stays quiet while the grant is low;
- each acknowledge moves the address up by one and the count down by one;
- the interrupt holds until a control write;
- both the last word and a zero-count go end with the interrupt and no bus request.

Other behaviour only the bench scenarios can show:
- register read-back and the ignored code 11;
- that a held peripheral request never yields a second word;
- that writes are blocked during the grant;
- the exact order of the addresses and strobe direction, compared against a scoreboard of expected words.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_XFER  = 2'd2,
        ST_HOLD  = 2'd3
    } dma_state_e;

    localparam logic [1:0] SEL_ADDR  = 2'b00;
    localparam logic [1:0] SEL_COUNT = 2'b01;
    localparam logic [1:0] SEL_CTRL  = 2'b10;

    // control write fields
    localparam int CTRL_DIR  = 0;
    localparam int CTRL_GO   = 1;
    // control read fields
    localparam int CTRL_BUSY = 1;
    localparam int CTRL_IRQ  = 2;

endpackage

// File: rtl/blkdma_cpu_port.sv
module blkdma_cpu_port
    import blkdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          dma_sel,
    input  logic [1:0]    reg_sel,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic          bus_grant,
    input  logic [AW-1:0] cur_addr,
    input  logic [CW-1:0] cur_cnt,
    input  logic          cur_dir,
    input  logic          cur_busy,
    input  logic          cur_irq,
    output logic          wr_addr,
    output logic          wr_cnt,
    output logic          wr_ctrl,
    output logic [DW-1:0] rdata,
    output logic          rdata_en
);

    logic access_ok;

    // register port is only open while the CPU owns the bus
    assign access_ok = dma_sel && !bus_grant;
    assign wr_addr   = access_ok && cpu_wr && (reg_sel == SEL_ADDR);
    assign wr_cnt    = access_ok && cpu_wr && (reg_sel == SEL_COUNT);
    assign wr_ctrl   = access_ok && cpu_wr && (reg_sel == SEL_CTRL);
    assign rdata_en  = access_ok && cpu_rd;

    always_comb begin
        rdata = '0;
        if (rdata_en) begin
            case (reg_sel)
                SEL_ADDR:  rdata[AW-1:0] = cur_addr;
                SEL_COUNT: rdata[CW-1:0] = cur_cnt;
                SEL_CTRL: begin
                    rdata[CTRL_DIR]  = cur_dir;
                    rdata[CTRL_BUSY] = cur_busy;
                    rdata[CTRL_IRQ]  = cur_irq;
                end
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
    import blkdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          wr_ctrl,
    input  logic [DW-1:0] wdata,
    input  logic          bus_grant,
    input  logic          periph_req,
    output dma_state_e    state,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cnt,
    output logic          dir,
    output logic          active,
    output logic          irq
);

    localparam logic [AW-1:0] ADDR_STEP = AW'(1);
    localparam logic [CW-1:0] CNT_STEP  = CW'(1);
    localparam logic [CW-1:0] CNT_ZERO  = '0;

    typedef struct packed {
        dma_state_e    st;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          dir;
        logic          active;
        logic          irq;
    } eng_t;

    eng_t          r_q, r_d;
    logic [CW-1:0] cnt_next_q;

    assign cnt_next_q = r_q.cnt - CNT_STEP;

    always_comb begin
        r_d = r_q;

        case (r_q.st)
            ST_READY: begin
                if (bus_grant && periph_req) begin
                    r_d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                // a word completes only while the bus is actually held
                if (bus_grant) begin
                    r_d.addr = r_q.addr + ADDR_STEP;
                    r_d.cnt  = cnt_next_q;
                    if (cnt_next_q == CNT_ZERO) begin
                        r_d.st     = ST_IDLE;
                        r_d.active = 1'b0;
                        r_d.irq    = 1'b1;
                    end else begin
                        r_d.st = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (!periph_req) begin
                    r_d.st = ST_READY;
                end
            end
            default: r_d.st = r_q.st;
        endcase

        if (wr_addr) begin
            r_d.addr = wdata[AW-1:0];
        end
        if (wr_cnt) begin
            r_d.cnt = wdata[CW-1:0];
        end
        if (wr_ctrl) begin
            r_d.dir = wdata[CTRL_DIR];
            r_d.irq = 1'b0;
            if (wdata[CTRL_GO]) begin
                if (r_q.cnt == CNT_ZERO) begin
                    r_d.irq    = 1'b1;
                    r_d.active = 1'b0;
                    r_d.st     = ST_IDLE;
                end else begin
                    r_d.active = 1'b1;
                    r_d.st     = ST_READY;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state  = r_q.st;
    assign addr   = r_q.addr;
    assign cnt    = r_q.cnt;
    assign dir    = r_q.dir;
    assign active = r_q.active;
    assign irq    = r_q.irq;

endmodule

// File: rtl/blkdma_bus_drive.sv
module blkdma_bus_drive
    import blkdma_pkg::*;
#(
    parameter int AW = 16
) (
    input  dma_state_e    state,
    input  logic          dir,
    input  logic [AW-1:0] addr,
    input  logic          bus_grant,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          periph_ack
);

    logic cycle_live;

    assign cycle_live = (state == ST_XFER) && bus_grant;
    assign mem_addr   = bus_grant ? addr : '0;
    assign mem_rd     = cycle_live && !dir;
    assign mem_wr     = cycle_live && dir;
    assign periph_ack = cycle_live;

endmodule

// File: rtl/blkdma_top.sv
module blkdma_top
    import blkdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_sel,
    input  logic [1:0]    reg_sel,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_rdata_en,
    input  logic          bus_grant,
    output logic          bus_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic          periph_req,
    output logic          periph_ack,
    output logic          irq
);

    logic          wr_addr, wr_cnt, wr_ctrl;
    dma_state_e    eng_state;
    logic [AW-1:0] eng_addr;
    logic [CW-1:0] eng_cnt;
    logic          eng_dir, eng_active, eng_irq;

    blkdma_cpu_port #(.AW(AW), .CW(CW), .DW(DW)) u_port (
        .dma_sel   (dma_sel),
        .reg_sel   (reg_sel),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .bus_grant (bus_grant),
        .cur_addr  (eng_addr),
        .cur_cnt   (eng_cnt),
        .cur_dir   (eng_dir),
        .cur_busy  (eng_active),
        .cur_irq   (eng_irq),
        .wr_addr   (wr_addr),
        .wr_cnt    (wr_cnt),
        .wr_ctrl   (wr_ctrl),
        .rdata     (cpu_rdata),
        .rdata_en  (cpu_rdata_en)
    );

    blkdma_engine #(.AW(AW), .CW(CW), .DW(DW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_addr    (wr_addr),
        .wr_cnt     (wr_cnt),
        .wr_ctrl    (wr_ctrl),
        .wdata      (cpu_wdata),
        .bus_grant  (bus_grant),
        .periph_req (periph_req),
        .state      (eng_state),
        .addr       (eng_addr),
        .cnt        (eng_cnt),
        .dir        (eng_dir),
        .active     (eng_active),
        .irq        (eng_irq)
    );

    blkdma_bus_drive #(.AW(AW)) u_drive (
        .state      (eng_state),
        .dir        (eng_dir),
        .addr       (eng_addr),
        .bus_grant  (bus_grant),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .periph_ack (periph_ack)
    );

    assign bus_req = eng_active;
    assign irq     = eng_irq;

endmodule

// File: rtl/blkdma_checker.sv
module blkdma_checker
    import blkdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dma_sel,
    input logic [1:0]    reg_sel,
    input logic          cpu_rd,
    input logic          cpu_wr,
    input logic [DW-1:0] cpu_wdata,
    input logic          cpu_rdata_en,
    input logic          bus_grant,
    input logic          bus_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          periph_ack,
    input logic          irq,
    input logic [AW-1:0] cur_addr,
    input logic [CW-1:0] cur_cnt
);

    logic ctrl_write;
    assign ctrl_write = dma_sel && cpu_wr && !bus_grant && (reg_sel == SEL_CTRL);

    p_read_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata_en |-> (!bus_grant && dma_sel && cpu_rd));

    p_ack_with_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> (bus_grant && bus_req && (mem_rd != mem_wr)));

    p_strobe_needs_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> periph_ack);

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |=> (cur_addr == $past(cur_addr) + AW'(1)));

    p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |=> (cur_cnt == $past(cur_cnt) - CW'(1)));

    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |=> !periph_ack);

    p_last_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_ack && cur_cnt == CW'(1)) |=> (!bus_req && irq));

    p_zero_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_write && cpu_wdata[CTRL_GO] && cur_cnt == '0) |=> (irq && !bus_req));

    p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ctrl_write) |=> irq);

    p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_write && !cpu_wdata[CTRL_GO]) |=> !irq);

    p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_grant |-> (!mem_rd && !mem_wr && !periph_ack && mem_addr == '0));

endmodule

bind blkdma_top blkdma_checker #(.AW(AW), .CW(CW), .DW(DW)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .dma_sel      (dma_sel),
    .reg_sel      (reg_sel),
    .cpu_rd       (cpu_rd),
    .cpu_wr       (cpu_wr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rdata_en (cpu_rdata_en),
    .bus_grant    (bus_grant),
    .bus_req      (bus_req),
    .mem_addr     (mem_addr),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .periph_ack   (periph_ack),
    .irq          (irq),
    .cur_addr     (eng_addr),
    .cur_cnt      (eng_cnt)
);

// File: tb/blkdma_top_test.sv
module blkdma_top_test;

    localparam logic [1:0] R_ADDR = 2'b00;
    localparam logic [1:0] R_CNT  = 2'b01;
    localparam logic [1:0] R_CTRL = 2'b10;
    localparam logic [1:0] R_NONE = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        dma_sel, cpu_rd, cpu_wr, bus_grant, periph_req;
    logic [1:0]  reg_sel;
    logic [15:0] cpu_wdata, cpu_rdata, mem_addr;
    logic        cpu_rdata_en, bus_req, mem_rd, mem_wr, periph_ack, irq;

    int n_checks = 0;
    int n_fail   = 0;
    int ack_count = 0;
    bit done = 1'b0;

    // expected words: {dir, address}
    logic [16:0] exp_q[$];

    always #5 clk = ~clk;

    blkdma_top uut (
        .clk(clk), .rst_n(rst_n), .dma_sel(dma_sel), .reg_sel(reg_sel),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rdata_en(cpu_rdata_en),
        .bus_grant(bus_grant), .bus_req(bus_req), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .periph_req(periph_req),
        .periph_ack(periph_ack), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] s, input logic [15:0] v);
        dma_sel = 1'b1; reg_sel = s; cpu_wdata = v; cpu_wr = 1'b1;
        @(negedge clk);
        dma_sel = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0;
    endtask

    task automatic cpu_read(input logic [1:0] s, output logic [15:0] v, output logic en);
        dma_sel = 1'b1; reg_sel = s; cpu_rd = 1'b1;
        #1;
        v  = cpu_rdata;
        en = cpu_rdata_en;
        @(negedge clk);
        dma_sel = 1'b0; cpu_rd = 1'b0;
    endtask

    task automatic wait_ack(input string tag);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (periph_ack) return;
        end
        check(tag, 32'd0, 32'd1);
    endtask

    task automatic do_word(input string tag);
        periph_req = 1'b1;
        wait_ack(tag);
        periph_req = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (periph_ack) begin
                ack_count++;
                if (exp_q.size() == 0) begin
                    check("R5 unexpected word", 32'd1, 32'd0);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    check("R5 mem_addr", {16'd0, mem_addr}, {16'd0, e[15:0]});
                    check("R5 mem_rd", {31'd0, mem_rd}, {31'd0, ~e[16]});
                    check("R5 mem_wr", {31'd0, mem_wr}, {31'd0, e[16]});
                end
            end else if (mem_rd || mem_wr) begin
                check("R5 strobe without ack", 32'd1, 32'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic        en;
        int          acks0;

        rst_n = 1'b0; dma_sel = 0; cpu_rd = 0; cpu_wr = 0; reg_sel = '0;
        cpu_wdata = '0; bus_grant = 0; periph_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 bus_req", {31'd0, bus_req}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
        check("R1 ack", {31'd0, periph_ack}, 32'd0);
        cpu_read(R_ADDR, v, en); check("R1 addr", {16'd0, v}, 32'd0);
        cpu_read(R_CNT, v, en);  check("R1 count", {16'd0, v}, 32'd0);

        // R2 register map
        cpu_write(R_ADDR, 16'h1234);
        cpu_write(R_CNT, 16'd3);
        cpu_write(R_CTRL, 16'h0001);
        cpu_read(R_ADDR, v, en); check("R2 addr", {16'd0, v}, 32'h1234);
        check("R2 rdata_en", {31'd0, en}, 32'd1);
        cpu_read(R_CNT, v, en);  check("R2 count", {16'd0, v}, 32'd3);
        cpu_read(R_CTRL, v, en); check("R2 ctrl dir", {16'd0, v}, 32'h1);
        cpu_write(R_NONE, 16'hBEEF);
        cpu_read(R_NONE, v, en); check("R2 code 11 reads 0", {16'd0, v}, 32'd0);
        cpu_read(R_ADDR, v, en); check("R2 code 11 write ignored", {16'd0, v}, 32'h1234);

        // R3 port closed while granted
        bus_grant = 1'b1;
        cpu_write(R_ADDR, 16'hFFFF);
        cpu_read(R_ADDR, v, en);
        check("R3 rdata_en", {31'd0, en}, 32'd0);
        check("R3 rdata", {16'd0, v}, 32'd0);
        bus_grant = 1'b0;
        @(negedge clk);
        cpu_read(R_ADDR, v, en); check("R3 write ignored", {16'd0, v}, 32'h1234);

        // R4 R6 R8: three-word memory-read block
        cpu_write(R_CTRL, 16'h0002);
        check("R4 bus_req after go", {31'd0, bus_req}, 32'd1);
        bus_grant = 1'b1;
        exp_q.push_back({1'b0, 16'h1234});
        do_word("R5 word0");
        check("R4 bus_req held", {31'd0, bus_req}, 32'd1);
        bus_grant = 1'b0;
        @(negedge clk);
        cpu_read(R_CNT, v, en);  check("R6 count after 1", {16'd0, v}, 32'd2);
        cpu_read(R_ADDR, v, en); check("R6 addr after 1", {16'd0, v}, 32'h1235);
        bus_grant = 1'b1;
        exp_q.push_back({1'b0, 16'h1235});
        do_word("R5 word1");
        exp_q.push_back({1'b0, 16'h1236});
        do_word("R5 word2");
        check("R8 bus_req dropped", {31'd0, bus_req}, 32'd0);
        check("R8 irq raised", {31'd0, irq}, 32'd1);
        bus_grant = 1'b0;
        @(negedge clk);
        cpu_read(R_CNT, v, en);  check("R6 count end", {16'd0, v}, 32'd0);
        cpu_read(R_ADDR, v, en); check("R6 addr end", {16'd0, v}, 32'h1237);
        cpu_read(R_CTRL, v, en); check("R2 ctrl irq/busy", {16'd0, v}, 32'h4);

        // R10 interrupt holds until control write
        repeat (5) @(negedge clk);
        check("R10 irq held", {31'd0, irq}, 32'd1);
        cpu_write(R_CTRL, 16'h0000);
        check("R10 irq cleared", {31'd0, irq}, 32'd0);

        // R7 memory-write block with a held request
        cpu_write(R_ADDR, 16'h00F0);
        cpu_write(R_CNT, 16'd2);
        cpu_write(R_CTRL, 16'h0003);
        bus_grant = 1'b1;
        exp_q.push_back({1'b1, 16'h00F0});
        acks0 = ack_count;
        periph_req = 1'b1;
        wait_ack("R7 first word");
        repeat (5) @(negedge clk);
        check("R7 one word per request", ack_count - acks0, 32'd1);
        check("R7 still busy", {31'd0, bus_req}, 32'd1);
        periph_req = 1'b0;
        repeat (2) @(negedge clk);
        exp_q.push_back({1'b1, 16'h00F1});
        do_word("R7 second word");
        check("R7 total words", ack_count - acks0, 32'd2);
        check("R8 irq write block", {31'd0, irq}, 32'd1);
        check("R8 bus_req write block", {31'd0, bus_req}, 32'd0);
        bus_grant = 1'b0;
        @(negedge clk);
        cpu_write(R_CTRL, 16'h0000);

        // R9 zero-count go
        cpu_write(R_CNT, 16'd0);
        cpu_write(R_CTRL, 16'h0002);
        check("R9 irq at once", {31'd0, irq}, 32'd1);
        check("R9 no bus_req", {31'd0, bus_req}, 32'd0);
        cpu_read(R_CTRL, v, en); check("R9 ctrl not busy", {16'd0, v}, 32'h4);
        cpu_write(R_CTRL, 16'h0000);

        // R11 request held off without grant
        cpu_write(R_ADDR, 16'h0400);
        cpu_write(R_CNT, 16'd1);
        cpu_write(R_CTRL, 16'h0002);
        acks0 = ack_count;
        periph_req = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 no ack without grant", ack_count - acks0, 32'd0);
        check("R11 addr quiet", {16'd0, mem_addr}, 32'd0);
        check("R11 strobes quiet", {30'd0, mem_rd, mem_wr}, 32'd0);
        exp_q.push_back({1'b0, 16'h0400});
        bus_grant = 1'b1;
        wait_ack("R11 word after grant");
        periph_req = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 single-word irq", {31'd0, irq}, 32'd1);
        bus_grant = 1'b0;

        check("R5 scoreboard drained", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule